// File: doc/BRIEF.md
# Page-Granular SRAM Write Guard

This block sits between a bus master and a secondary SRAM and filters the write traffic going to the memory. The SRAM is split into 1 KB pages, and each page has one protection bit. The protection bits live in a 32-bit register. Software can set these bits, but only a system reset clears them. Once a page is protected it stays protected for the rest of the power cycle.

Every memory request goes through the guard in the same cycle. Reads always pass through. A write passes through unless its page is protected. When a write is blocked, the guard holds back the request and raises an error pulse on the next cycle. The configuration side is a plain address/data write port, and the current protection mask is always visible on an output. The SRAM array and any erase engine sit outside the block, and an erase engine may drive the memory directly around the guard.

Top module: `sram_page_guard`

## Requirements
- R1: After a synchronous active-low reset, `prot_mask` is all zeros and `wr_err` is 0.
- R2: A configuration write with `cfg_wr_addr == PROT_REG_ADDR` sets every `prot_mask` bit i (i < NUM_PAGES) whose `cfg_wr_data` bit i is 1. The new value is visible from the next cycle.
- R3: A 0 written to a protection bit leaves that bit unchanged, so a set bit is cleared only by reset.
- R4: `prot_mask` bits at positions NUM_PAGES and above always read 0 and cannot be set.
- R5: A configuration write to any address other than `PROT_REG_ADDR` does not change `prot_mask`.
- R6: A write request (`in_req=1`, `in_we=1`) is blocked in the same cycle when the page index `in_addr[14:10]` selects a `prot_mask` bit that is 1. While blocked, `mem_req` and `mem_we` are both 0.
- R7: A write request to a page whose bit is 0 is forwarded in the same cycle: `mem_req=1`, `mem_we=1`, and `mem_addr`/`mem_wdata` equal `in_addr`/`in_wdata`.
- R8: A read request (`in_req=1`, `in_we=0`) is always forwarded with `mem_req=1`, `mem_we=0` and `mem_addr == in_addr`, whatever the protection state.
- R9: `wr_err` is 1 for exactly the one cycle that follows each blocked write, and 0 in every other cycle.
- R10: A memory write issued in the same cycle as the configuration write that protects its page still passes. Writes to that page are blocked from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | Configuration write address |
| cfg_wr_data | input | 32 | Configuration write data; each 1 bit requests protection of that page |
| prot_mask | output | 32 | Current page protection bits, bit i covers page i |
| in_req | input | 1 | Memory request valid from the master |
| in_we | input | 1 | 1 = write, 0 = read |
| in_addr | input | ADDR_W | Byte address of the request |
| in_wdata | input | DATA_W | Write data |
| mem_req | output | 1 | Request forwarded to the SRAM |
| mem_we | output | 1 | Write enable forwarded to the SRAM |
| mem_addr | output | ADDR_W | Address forwarded to the SRAM |
| mem_wdata | output | DATA_W | Write data forwarded to the SRAM |
| wr_err | output | 1 | One-cycle pulse after a blocked write |

## Verification
The assertions check the following on every cycle:
- No protection bit ever drops while reset is inactive.
- Mask bits above the page count stay 0.
- Reads are forwarded, and writes to protected pages are withheld.
- `wr_err` fires exactly after each blocked write.

These checks use the visible mask as the reference for which pages are protected. Only the bench scenarios can show that the mask reaches the expected values. Those scenarios cover the accumulating set-only behaviour, the writes of 0, the writes to a wrong address, and the one-cycle race between a protecting register write and a memory write to the same page. The bench uses a reduced page count so that it can also sweep every page index, including the indices above the configured count.

// File: rtl/sram_guard_pkg.sv
// Package: shared constants and helpers for the SRAM page write guard.
// Assumes pages are 1 KB and the protection register is 32 bits wide.
package sram_guard_pkg;

    localparam int PROT_BITS = 32;               // width of the protection register
    localparam int PAGE_LSB  = 10;               // log2 of the page size in bytes
    localparam int IDX_W     = $clog2(PROT_BITS); // page index width

    typedef logic [PROT_BITS-1:0] prot_vec_t;
    typedef logic [IDX_W-1:0]     page_idx_t;

    // Mask with ones at positions below n: the implemented pages.
    function automatic prot_vec_t implemented_pages(input int n);
        prot_vec_t m;
        for (int i = 0; i < PROT_BITS; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/page_prot_reg.sv
// Module: set-only page protection register.
// What it does: each implemented bit is a sticky flop that is set by a
// configuration write carrying a 1 in its position. Only reset clears it.
// Assumes: NUM_PAGES <= PROT_BITS; unimplemented bits are tied to 0.
module page_prot_reg
    import sram_guard_pkg::*;
#(
    parameter int NUM_PAGES = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_en,
    input  prot_vec_t set_bits,
    output prot_vec_t prot_q
);

    genvar gi;
    generate
        for (gi = 0; gi < PROT_BITS; gi++) begin : g_bit
            if (gi < NUM_PAGES) begin : g_impl
                logic bit_q;
                // Sticky bit: reset clears it, a written 1 sets it, a written 0 keeps it.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        bit_q <= 1'b0;
                    end else if (set_en && set_bits[gi]) begin
                        bit_q <= 1'b1;
                    end
                end
                assign prot_q[gi] = bit_q;
            end else begin : g_absent
                assign prot_q[gi] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/page_lookup.sv
// Module: page protection lookup.
// What it does: selects the protection bit named by a page index.
// Assumes: the index range matches the register width, so every index is in range.
module page_lookup
    import sram_guard_pkg::*;
(
    input  page_idx_t page_idx,
    input  prot_vec_t prot_bits,
    output logic      page_locked
);

    // Pick the protection bit of the addressed page.
    always_comb begin
        page_locked = prot_bits[page_idx];
    end

endmodule

// File: rtl/write_gate.sv
// Module: request gate with error pulse.
// What it does: forwards reads and unlocked writes combinationally and
// withholds writes to locked pages. It raises a registered one-cycle error
// after each withheld write.
// Assumes: the downstream SRAM ignores mem_addr and mem_wdata when mem_req is 0.
module write_gate #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req,
    input  logic              in_we,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              page_locked,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_err
);

    logic blocked;

    // Decide whether this cycle's request is a write to a locked page.
    always_comb begin
        blocked = in_req && in_we && page_locked;
    end

    // Forward the request unless it is blocked; address and data go straight through.
    always_comb begin
        mem_req   = in_req && !blocked;
        mem_we    = in_we && in_req && !blocked;
        mem_addr  = in_addr;
        mem_wdata = in_wdata;
    end

    // Register the error so it lasts exactly one cycle per blocked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= blocked;
        end
    end

endmodule

// File: rtl/sram_page_guard.sv
// Module: top of the page-granular SRAM write guard.
// What it does: holds per-page set-only protection bits, written through a
// simple address/data port, and filters memory writes by 1 KB page.
// Assumes: ADDR_W >= 15, so the page index is in_addr[14:10]; NUM_PAGES <= 32.
module sram_page_guard
    import sram_guard_pkg::*;
#(
    parameter int          NUM_PAGES     = 32,
    parameter int          ADDR_W        = 15,
    parameter int          DATA_W        = 32,
    parameter int          CFG_AW        = 4,
    parameter logic [3:0]  PROT_REG_ADDR = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       prot_mask,
    input  logic              in_req,
    input  logic              in_we,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_err
);

    localparam logic [CFG_AW-1:0] REG_SEL = CFG_AW'(PROT_REG_ADDR);

    logic      reg_hit;
    prot_vec_t prot_q;
    page_idx_t page_idx;
    logic      page_locked;

    // Decode a configuration write aimed at the protection register.
    always_comb begin
        reg_hit = cfg_wr_en && (cfg_wr_addr == REG_SEL);
    end

    // Extract the 1 KB page index from the byte address.
    always_comb begin
        page_idx = in_addr[PAGE_LSB +: IDX_W];
    end

    page_prot_reg #(
        .NUM_PAGES(NUM_PAGES)
    ) u_prot_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (reg_hit),
        .set_bits(cfg_wr_data),
        .prot_q  (prot_q)
    );

    page_lookup u_lookup (
        .page_idx   (page_idx),
        .prot_bits  (prot_q),
        .page_locked(page_locked)
    );

    write_gate #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_req     (in_req),
        .in_we      (in_we),
        .in_addr    (in_addr),
        .in_wdata   (in_wdata),
        .page_locked(page_locked),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wr_err     (wr_err)
    );

    // Expose the protection bits.
    always_comb begin
        prot_mask = prot_q;
    end

endmodule

// File: rtl/sram_page_guard_chk.sv
// Checker: cycle-level properties of sram_page_guard, attached by bind.
// Assumes reset is held for at least two cycles at start-up.
module sram_page_guard_chk #(
    parameter int          NUM_PAGES     = 32,
    parameter int          ADDR_W        = 15,
    parameter int          DATA_W        = 32,
    parameter int          CFG_AW        = 4,
    parameter logic [3:0]  PROT_REG_ADDR = 4'h8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_wr_addr,
    input logic [31:0]       cfg_wr_data,
    input logic [31:0]       prot_mask,
    input logic              in_req,
    input logic              in_we,
    input logic [ADDR_W-1:0] in_addr,
    input logic [DATA_W-1:0] in_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              wr_err
);

    localparam logic [31:0] VALID = sram_guard_pkg::implemented_pages(NUM_PAGES);

    logic cfg_hit;
    logic wr_locked;
    assign cfg_hit   = cfg_wr_en && (cfg_wr_addr == CFG_AW'(PROT_REG_ADDR));
    assign wr_locked = in_req && in_we && prot_mask[in_addr[14:10]];

    // R2
    set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> ((prot_mask & $past(cfg_wr_data & VALID)) == $past(cfg_wr_data & VALID)));

    // R3
    no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(prot_mask) & ~prot_mask) == 32'h0));

    // R4
    absent_pages_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mask & ~VALID) == 32'h0);

    // R5
    foreign_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> $stable(prot_mask));

    // R6
    locked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_locked |-> (!mem_req && !mem_we));

    // R7
    open_write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && in_we && !wr_locked) |->
            (mem_req && mem_we && mem_addr == in_addr && mem_wdata == in_wdata));

    // R8
    read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_we) |-> (mem_req && !mem_we && mem_addr == in_addr));

    // R9
    err_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_locked |=> wr_err);

    // R9
    err_only_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wr_err) |-> $past(wr_locked));

endmodule

bind sram_page_guard sram_page_guard_chk #(
    .NUM_PAGES    (NUM_PAGES),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CFG_AW       (CFG_AW),
    .PROT_REG_ADDR(PROT_REG_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data),
    .prot_mask  (prot_mask),
    .in_req     (in_req),
    .in_we      (in_we),
    .in_addr    (in_addr),
    .in_wdata   (in_wdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .wr_err     (wr_err)
);

// File: tb/test_sram_page_guard.sv
// Bench: sweeps every page index of a 20-page guard under several protection
// patterns. Expected values are computed arithmetically.
module test_sram_page_guard;

    localparam int         NP      = 20;
    localparam int         AW      = 15;
    localparam int         DW      = 32;
    localparam logic [3:0] REG_A   = 4'h8;
    localparam logic [31:0] LIMIT  = (32'h1 << NP) - 32'h1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [3:0]    cfg_wr_addr = 4'h0;
    logic [31:0]   cfg_wr_data = 32'h0;
    logic [31:0]   prot_mask;
    logic          in_req = 1'b0;
    logic          in_we = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_wdata = '0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          wr_err;

    int          total = 0;
    int          bad = 0;
    logic [31:0] exp_mask = 32'h0;

    always #10 clk = ~clk;

    sram_page_guard #(
        .NUM_PAGES(NP), .ADDR_W(AW), .DATA_W(DW), .CFG_AW(4), .PROT_REG_ADDR(REG_A)
    ) i_sram_page_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .prot_mask(prot_mask),
        .in_req(in_req), .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_err(wr_err)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write the protection register (or another address) and check the mask.
    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        if (a == REG_A) exp_mask = exp_mask | (d & LIMIT);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #2 check(prot_mask == exp_mask, req, prot_mask, exp_mask);
    endtask

    // Issue one memory access; check forwarding now and the error one cycle later.
    task automatic mem_access(input logic we, input int page, input logic [31:0] d);
        logic [AW-1:0] a;
        logic locked;
        a = AW'(page * 1024 + ((page * 37 + 4) % 1024));
        locked = we && exp_mask[page];
        @(negedge clk);
        in_req = 1'b1; in_we = we; in_addr = a; in_wdata = d;
        #2;
        if (!we) begin
            check(mem_req && !mem_we && mem_addr == a, "R8",
                  {29'h0, mem_req, mem_we, 1'b0}, 32'h4);
        end else if (locked) begin
            check(!mem_req && !mem_we, "R6", {30'h0, mem_req, mem_we}, 32'h0);
        end else begin
            check(mem_req && mem_we && mem_addr == a && mem_wdata == d, "R7",
                  {30'h0, mem_req, mem_we}, 32'h3);
        end
        @(negedge clk);
        check(wr_err == locked, "R9", {31'h0, wr_err}, {31'h0, locked});
        in_req = 1'b0; in_we = 1'b0;
    endtask

    task automatic sweep_all;
        for (int p = 0; p < 32; p++) begin
            mem_access(1'b1, p, 32'hA500_0000 + 32'(p));
            mem_access(1'b0, p, 32'h0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(prot_mask == 32'h0, "R1", prot_mask, 32'h0);
        check(wr_err == 1'b0, "R1", {31'h0, wr_err}, 32'h0);
        rst_n = 1'b1;

        // No protection: every write passes
        sweep_all();

        // R2 / R4: even pages, upper bits must be dropped
        cfg_write(REG_A, 32'h5555_5555, "R2");
        check((prot_mask & ~LIMIT) == 32'h0, "R4", prot_mask & ~LIMIT, 32'h0);
        sweep_all();

        // R3: writing zeros clears nothing
        cfg_write(REG_A, 32'h0000_0000, "R3");
        // R5: other address ignored
        cfg_write(4'h3, 32'hFFFF_FFFF, "R5");
        cfg_write(4'h9, 32'hFFFF_FFFF, "R5");
        mem_access(1'b1, 1, 32'h1111_1111);

        // R10: protecting write and memory write to page 1 in the same cycle
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = REG_A; cfg_wr_data = 32'h0000_0002;
        in_req = 1'b1; in_we = 1'b1; in_addr = AW'(1024 + 8); in_wdata = 32'hBEEF;
        #2 check(mem_req && mem_we, "R10", {30'h0, mem_req, mem_we}, 32'h3);
        exp_mask = exp_mask | 32'h2;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(wr_err == 1'b0, "R10", {31'h0, wr_err}, 32'h0);
        #2 check(!mem_req && !mem_we, "R10", {30'h0, mem_req, mem_we}, 32'h0);
        @(negedge clk);
        check(wr_err == 1'b1, "R10", {31'h0, wr_err}, 32'h1);
        in_req = 1'b0; in_we = 1'b0;
        @(negedge clk);
        check(wr_err == 1'b0, "R9", {31'h0, wr_err}, 32'h0);

        // R2 / R4: set everything; pages 20..31 stay open
        cfg_write(REG_A, 32'hFFFF_FFFF, "R2");
        check(prot_mask == LIMIT, "R4", prot_mask, LIMIT);
        sweep_all();

        // R1: reset clears all protection
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_mask = 32'h0;
        check(prot_mask == 32'h0, "R1", prot_mask, 32'h0);
        mem_access(1'b1, 5, 32'h5555);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule